// File: doc/BRIEF.md
# Command-Word Bus Master

This block sits behind a command-word front end and turns each 34-bit command word into at most one single-beat read or write on a Wishbone classic bus. The two top bits of a word choose the action; the low 32 bits carry a write value or an address. A command arrives as a one-cycle strobe and produces no acknowledgement of its own.

The master keeps its own byte-address register. A set-address word either loads the register or adds an offset to it. The same word also chooses whether the register advances by four after every completed access. Read data, write acknowledgements and bus errors come back as one-cycle pulses. A busy flag covers the time the bus cycle is open, so an upstream queue can hold the next word until the flag drops.

Top module: `dbg_bus_master`

## Requirements
- R1: A command word with top bits 2'b11 has no effect: no bus cycle opens and the address register is unchanged.
- R2: A read word (top bits 2'b00) accepted in cycle T makes wb_cyc and wb_stb high from cycle T+1 with wb_we low and wb_adr equal to the byte address shifted right by two. These values are held until wb_ack or wb_err is sampled.
- R3: A write word (top bits 2'b01) opens the same kind of cycle with wb_we high and wb_dat_o equal to bits 31:0 of the word.
- R4: A set-address word (top bits 2'b10) with bit 1 clear loads bits 31:2 of its payload into the address and clears address bits 1:0. It opens no bus cycle.
- R5: A set-address word with bit 1 set adds its payload, with bits 1:0 cleared, to the current address, modulo 2^32.
- R6: Bit 0 of a set-address word set to 0 makes the address advance by 4 (modulo 2^32) after every acknowledged access. Bit 0 set to 1 holds the address.
- R7: In the cycle after wb_ack on a read, wb_cyc and wb_stb are low and rd_valid pulses for one cycle. In that cycle rd_data holds the returned data and rd_addr holds the byte address that was read.
- R8: In the cycle after wb_ack on a write, wr_ack pulses for one cycle and the cycle is closed.
- R9: In the cycle after wb_err, bus_err pulses for one cycle and the cycle is closed. Neither rd_valid nor wr_ack pulses, and the address does not advance.
- R10: busy is high exactly while a bus cycle is open. Command strobes seen while busy is high are dropped.
- R11: While rst_n is low at a clock edge (a synchronous reset), any open cycle is aborted and all strobes are low. After reset, the address register is 0 with auto-advance enabled.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cmd_valid | input | 1 | One-cycle command strobe |
| cmd_word | input | 34 | Opcode in bits 33:32, payload in bits 31:0 |
| busy | output | 1 | Bus cycle open; commands dropped |
| rd_valid | output | 1 | Read result pulse |
| rd_data | output | 32 | Data returned by the read |
| rd_addr | output | 32 | Byte address of the read |
| wr_ack | output | 1 | Write completion pulse |
| bus_err | output | 1 | Error completion pulse |
| wb_cyc_o | output | 1 | Wishbone cycle |
| wb_stb_o | output | 1 | Wishbone strobe |
| wb_we_o | output | 1 | Wishbone write enable |
| wb_adr_o | output | 30 | Wishbone word address |
| wb_dat_o | output | 32 | Wishbone write data |
| wb_dat_i | input | 32 | Wishbone read data |
| wb_ack_i | input | 1 | Wishbone acknowledge |
| wb_err_i | input | 1 | Wishbone error |

## Verification
The bench builds the block with its default 32-bit data and address width. At this width a relative offset of 0xFFFFFFF0 acts as a step backwards, and an auto-advance from 0xFFFFFFFC wraps to zero. Both edges of the address arithmetic can therefore be reached in a few commands. The bench's bus slave replies after a chosen delay, which keeps a cycle open long enough to check that the bus signals are held and that commands arriving meanwhile are dropped.

// File: rtl/dbgm_pkg.sv
// Package: shared opcode type and widths for the command-word bus master.
package dbgm_pkg;
    typedef enum logic [1:0] {
        OP_READ   = 2'b00,
        OP_WRITE  = 2'b01,
        OP_SETADR = 2'b10,
        OP_NONE   = 2'b11
    } op_e;

    localparam int unsigned OP_W = 2;
endpackage

// File: rtl/dbgm_cmd_decode.sv
// Command decoder.
// Splits an incoming command word into one-hot action strobes.
// Assumes: a strobe is only acted on while no bus cycle is open
// (gate = !busy); opcode 2'b11 yields no action.
module dbgm_cmd_decode
    import dbgm_pkg::*;
#(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned CMD_W = DATA_W + OP_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    input  logic              idle,
    output logic              go_read,
    output logic              go_write,
    output logic              go_setadr,
    output logic [DATA_W-1:0] payload
);
    op_e  op;
    logic take;

    // Purpose: pick out the opcode and gate acceptance on the idle state.
    always_comb begin
        op        = op_e'(cmd_word[CMD_W-1 -: OP_W]);
        take      = cmd_valid && idle;
        payload   = cmd_word[DATA_W-1:0];
        go_read   = take && (op == OP_READ);
        go_write  = take && (op == OP_WRITE);
        go_setadr = take && (op == OP_SETADR);
    end

    // R1: an idle-opcode word never produces an action
    a_r1_none_ignored: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cmd_word[CMD_W-1 -: OP_W] == 2'b11) |-> !(go_read || go_write || go_setadr));
    // R10: nothing is accepted while a cycle is open
    a_r10_drop_when_busy: assert property (@(posedge clk) disable iff (!rst_n)
        !idle |-> !(go_read || go_write || go_setadr));
endmodule

// File: rtl/dbgm_addr_unit.sv
// Address register.
// Holds the byte address and the auto-advance enable. A set-address word
// loads or offsets the address; a completed access advances it by STEP.
// Assumes: set_en and step_en are never high together (set only when idle,
// step only at the close of an open cycle).
module dbgm_addr_unit #(
    parameter int unsigned ADDR_W = 32,
    parameter int unsigned STEP   = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              set_en,
    input  logic [ADDR_W-1:0] set_val,
    input  logic              step_en,
    output logic [ADDR_W-1:0] addr
);
    localparam int unsigned FLAG_REL  = 1;
    localparam int unsigned FLAG_HOLD = 0;

    logic [ADDR_W-1:0] addr_q;
    logic              adv_q;
    logic [ADDR_W-1:0] offs;
    logic [ADDR_W-1:0] addend;
    logic [ADDR_W-1:0] base;
    logic [ADDR_W-1:0] sum;

    // Purpose: share one adder between relative load and auto-advance.
    always_comb begin
        offs   = {set_val[ADDR_W-1:2], 2'b00};
        base   = (set_en && !set_val[FLAG_REL]) ? '0 : addr_q;
        addend = set_en ? offs : ADDR_W'(STEP);
        sum    = base + addend;
    end

    // Purpose: update the address register and the advance mode.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q <= '0;
            adv_q  <= 1'b1;
        end else if (set_en) begin
            addr_q <= sum;
            adv_q  <= !set_val[FLAG_HOLD];
        end else if (step_en && adv_q) begin
            addr_q <= sum;
        end
    end

    assign addr = addr_q;

    // R6: advance by STEP when enabled
    a_r6_advance: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && adv_q) |=> (addr_q == $past(addr_q) + ADDR_W'(STEP)));
    // R6: hold when advance is disabled
    a_r6_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && !adv_q) |=> $stable(addr_q));
    // R10: a load cannot coincide with a completion
    a_r10_no_overlap: assert property (@(posedge clk) disable iff (!rst_n)
        !(set_en && step_en));
    // R4: an absolute load leaves the low bits clear
    a_r4_aligned: assert property (@(posedge clk) disable iff (!rst_n)
        (set_en && !set_val[FLAG_REL]) |=> (addr_q[1:0] == 2'b00));
endmodule

// File: rtl/dbgm_wb_engine.sv
// Wishbone classic single-beat engine.
// Opens one cycle per accepted read or write, holds every bus signal until
// ack or err, closes on the following edge and reports the outcome as a
// one-cycle pulse. Assumes: err wins if a slave raises ack and err together.
module dbgm_wb_engine #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned ADDR_W = 32,
    localparam int unsigned WADR_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              go_read,
    input  logic              go_write,
    input  logic [ADDR_W-1:0] addr,
    input  logic [DATA_W-1:0] wdata,
    output logic              open,
    output logic              step_en,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_ack,
    output logic              bus_err,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [WADR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i,
    input  logic              wb_err_i
);
    logic              cyc_q;
    logic              we_q;
    logic [WADR_W-1:0] adr_q;
    logic [DATA_W-1:0] dat_q;
    logic              done;

    // Purpose: detect the end of an open cycle and a good completion.
    always_comb begin
        done    = cyc_q && (wb_ack_i || wb_err_i);
        step_en = cyc_q && wb_ack_i && !wb_err_i;
    end

    // Purpose: open, hold and close the bus cycle.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cyc_q <= 1'b0;
        end else if (!cyc_q) begin
            cyc_q <= go_read || go_write;
        end else if (done) begin
            cyc_q <= 1'b0;
        end
    end

    // Purpose: latch request attributes when a cycle opens.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            we_q  <= 1'b0;
            adr_q <= '0;
            dat_q <= '0;
        end else if (!cyc_q && (go_read || go_write)) begin
            we_q  <= go_write;
            adr_q <= addr[ADDR_W-1:2];
            dat_q <= wdata;
        end
    end

    // Purpose: produce the one-cycle result pulses and capture read data.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_valid <= 1'b0;
            wr_ack   <= 1'b0;
            bus_err  <= 1'b0;
            rd_data  <= '0;
        end else begin
            rd_valid <= done && !wb_err_i && !we_q;
            wr_ack   <= done && !wb_err_i && we_q;
            bus_err  <= done && wb_err_i;
            if (done && !wb_err_i && !we_q) begin
                rd_data <= wb_dat_i;
            end
        end
    end

    assign open     = cyc_q;
    assign wb_cyc_o = cyc_q;
    assign wb_stb_o = cyc_q;
    assign wb_we_o  = we_q;
    assign wb_adr_o = adr_q;
    assign wb_dat_o = dat_q;
    assign rd_addr  = {adr_q, 2'b00};

    // R2: request held steady until the slave answers
    a_r2_hold_request: assert property (@(posedge clk) disable iff (!rst_n)
        (cyc_q && !wb_ack_i && !wb_err_i) |=> (cyc_q && $stable(adr_q) && $stable(we_q) && $stable(dat_q)));
    // R7: cycle closes on the edge after an answer
    a_r7_close: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !wb_cyc_o);
    // R7: a read result is a single-cycle pulse
    a_r7_rd_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |=> !rd_valid);
    // R8: a write acknowledgement is a single-cycle pulse
    a_r8_wr_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        wr_ack |=> !wr_ack);
    // R9: at most one outcome pulse at a time
    a_r9_one_outcome: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({rd_valid, wr_ack, bus_err}));
    // R9: an error completion never advances the address
    a_r9_err_no_step: assert property (@(posedge clk) disable iff (!rst_n)
        wb_err_i |-> !step_en);
endmodule

// File: rtl/dbg_bus_master.sv
// Command-word bus master (top).
// Accepts 34-bit command words and performs single Wishbone classic
// accesses at an internal, optionally auto-advancing byte address.
// Assumes: upstream holds further commands while busy is high.
module dbg_bus_master #(
    parameter int unsigned DATA_W = 32,
    localparam int unsigned ADDR_W = DATA_W,
    localparam int unsigned CMD_W  = DATA_W + 2,
    localparam int unsigned WADR_W = ADDR_W - 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cmd_valid,
    input  logic [CMD_W-1:0]  cmd_word,
    output logic              busy,
    output logic              rd_valid,
    output logic [DATA_W-1:0] rd_data,
    output logic [ADDR_W-1:0] rd_addr,
    output logic              wr_ack,
    output logic              bus_err,
    output logic              wb_cyc_o,
    output logic              wb_stb_o,
    output logic              wb_we_o,
    output logic [WADR_W-1:0] wb_adr_o,
    output logic [DATA_W-1:0] wb_dat_o,
    input  logic [DATA_W-1:0] wb_dat_i,
    input  logic              wb_ack_i,
    input  logic              wb_err_i
);
    logic              go_read;
    logic              go_write;
    logic              go_setadr;
    logic [DATA_W-1:0] payload;
    logic [ADDR_W-1:0] addr;
    logic              open;
    logic              step_en;

    dbgm_cmd_decode #(.DATA_W(DATA_W)) u_decode (
        .clk       (clk),
        .rst_n     (rst_n),
        .cmd_valid (cmd_valid),
        .cmd_word  (cmd_word),
        .idle      (!open),
        .go_read   (go_read),
        .go_write  (go_write),
        .go_setadr (go_setadr),
        .payload   (payload)
    );

    dbgm_addr_unit #(.ADDR_W(ADDR_W), .STEP(4)) u_addr (
        .clk     (clk),
        .rst_n   (rst_n),
        .set_en  (go_setadr),
        .set_val (payload),
        .step_en (step_en),
        .addr    (addr)
    );

    dbgm_wb_engine #(.DATA_W(DATA_W), .ADDR_W(ADDR_W)) u_engine (
        .clk      (clk),
        .rst_n    (rst_n),
        .go_read  (go_read),
        .go_write (go_write),
        .addr     (addr),
        .wdata    (payload),
        .open     (open),
        .step_en  (step_en),
        .rd_valid (rd_valid),
        .rd_data  (rd_data),
        .rd_addr  (rd_addr),
        .wr_ack   (wr_ack),
        .bus_err  (bus_err),
        .wb_cyc_o (wb_cyc_o),
        .wb_stb_o (wb_stb_o),
        .wb_we_o  (wb_we_o),
        .wb_adr_o (wb_adr_o),
        .wb_dat_o (wb_dat_o),
        .wb_dat_i (wb_dat_i),
        .wb_ack_i (wb_ack_i),
        .wb_err_i (wb_err_i)
    );

    assign busy = open;

    // R10: busy mirrors the open bus cycle
    a_r10_busy_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        busy == wb_cyc_o);
    // R11: reset leaves no cycle open and no pulse
    a_r11_reset_quiet: assert property (@(posedge clk)
        !rst_n |=> !(wb_cyc_o || rd_valid || wr_ack || bus_err));
endmodule

// File: tb/test_dbg_bus_master.sv
module test_dbg_bus_master;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [33:0] cmd_word = '0;
    logic        busy, rd_valid, wr_ack, bus_err;
    logic [31:0] rd_data, rd_addr;
    logic        wb_cyc, wb_stb, wb_we;
    logic [29:0] wb_adr;
    logic [31:0] wb_dat_o;
    logic [31:0] wb_dat_i = '0;
    logic        wb_ack = 1'b0;
    logic        wb_err = 1'b0;

    int checks = 0;
    int errors = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    dbg_bus_master i_dbg_bus_master (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_word(cmd_word),
        .busy(busy), .rd_valid(rd_valid), .rd_data(rd_data), .rd_addr(rd_addr),
        .wr_ack(wr_ack), .bus_err(bus_err), .wb_cyc_o(wb_cyc), .wb_stb_o(wb_stb),
        .wb_we_o(wb_we), .wb_adr_o(wb_adr), .wb_dat_o(wb_dat_o), .wb_dat_i(wb_dat_i),
        .wb_ack_i(wb_ack), .wb_err_i(wb_err)
    );

    // Vector: {command[33:0], expected byte address[31:0], ack delay[1:0]}
    localparam int NV = 21;
    localparam logic [67:0] VEC [0:NV-1] = '{
        {34'h2_0000_2040, 32'h0000_0000, 2'd0},  // R4 absolute, advance on
        {34'h0_0000_0000, 32'h0000_2040, 2'd0},  // R6 four reads in order
        {34'h0_0000_0000, 32'h0000_2044, 2'd1},
        {34'h0_0000_0000, 32'h0000_2048, 2'd0},
        {34'h0_0000_0000, 32'h0000_204C, 2'd2},
        {34'h1_DEAD_BEEF, 32'h0000_2050, 2'd1},  // R3 write
        {34'h2_0000_1001, 32'h0000_0000, 2'd0},  // R6 hold mode
        {34'h0_0000_0000, 32'h0000_1000, 2'd0},
        {34'h1_0000_0005, 32'h0000_1000, 2'd0},
        {34'h2_0000_0022, 32'h0000_0000, 2'd0},  // R5 relative +0x20
        {34'h0_0000_0000, 32'h0000_1020, 2'd1},
        {34'h0_0000_0000, 32'h0000_1024, 2'd0},
        {34'h2_FFFF_FFF2, 32'h0000_0000, 2'd0},  // R5 relative -0x10
        {34'h0_0000_0000, 32'h0000_1018, 2'd0},
        {34'h2_FFFF_FFFD, 32'h0000_0000, 2'd0},  // R4 low bits cleared, hold
        {34'h0_0000_0000, 32'hFFFF_FFFC, 2'd0},
        {34'h0_0000_0000, 32'hFFFF_FFFC, 2'd1},
        {34'h2_FFFF_FFFC, 32'h0000_0000, 2'd0},  // advance on, near top
        {34'h0_0000_0000, 32'hFFFF_FFFC, 2'd0},
        {34'h1_0000_00A5, 32'h0000_0000, 2'd0},  // R6 wrap to zero
        {34'h0_0000_0000, 32'h0000_0004, 2'd0}
    };

    task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_adr(input logic [33:0] cmd);
        @(negedge clk); cmd_valid = 1'b1; cmd_word = cmd;
        @(negedge clk); cmd_valid = 1'b0;
        chk(!wb_cyc && !busy, "R4 set-address opens no cycle", 64'(wb_cyc), 64'd0);
    endtask

    task automatic access(input logic [33:0] cmd, input logic [31:0] exp, input int dly,
                          input bit err, input bit poke);
        logic [31:0] rdat;
        bit          wr;
        rdat = exp ^ 32'h5A5A_00FF;
        wr   = cmd[32];
        @(negedge clk); cmd_valid = 1'b1; cmd_word = cmd;
        @(negedge clk); cmd_valid = 1'b0;
        chk(wb_cyc && wb_stb && busy, "R2 cycle open", 64'({wb_cyc, wb_stb, busy}), 64'h7);
        chk(wb_adr == exp[31:2], "R2 word address", 64'(wb_adr), 64'(exp[31:2]));
        chk(wb_we == wr, "R3 write enable", 64'(wb_we), 64'(wr));
        if (wr) chk(wb_dat_o == cmd[31:0], "R3 write data", 64'(wb_dat_o), 64'(cmd[31:0]));
        for (int i = 0; i < dly; i++) begin
            if (poke && i == 0) begin cmd_valid = 1'b1; cmd_word = 34'h1_1111_1111; end
            @(negedge clk);
            cmd_valid = 1'b0;
            chk(wb_cyc && wb_adr == exp[31:2], "R2 held while waiting", 64'(wb_adr), 64'(exp[31:2]));
        end
        if (err) wb_err = 1'b1; else wb_ack = 1'b1;
        wb_dat_i = rdat;
        @(negedge clk); wb_ack = 1'b0; wb_err = 1'b0;
        chk(!wb_cyc && !wb_stb && !busy, "R10 closed after answer", 64'({wb_cyc, busy}), 64'd0);
        if (err) begin
            chk(bus_err && !rd_valid && !wr_ack, "R9 error pulse only", 64'({bus_err, rd_valid, wr_ack}), 64'h4);
        end else if (wr) begin
            chk(wr_ack && !rd_valid && !bus_err, "R8 write ack pulse", 64'({wr_ack, rd_valid, bus_err}), 64'h4);
        end else begin
            chk(rd_valid && !wr_ack && !bus_err, "R7 read pulse", 64'({rd_valid, wr_ack, bus_err}), 64'h4);
            chk(rd_data == rdat, "R7 read data", 64'(rd_data), 64'(rdat));
            chk(rd_addr == exp, "R7 read address", 64'(rd_addr), 64'(exp));
        end
        @(negedge clk);
        chk(!rd_valid && !wr_ack && !bus_err && !wb_cyc, "R10 pulses end, no stray cycle",
            64'({rd_valid, wr_ack, bus_err, wb_cyc}), 64'd0);
    endtask

    initial begin
        // R11 reset state
        repeat (3) @(negedge clk);
        chk(!wb_cyc && !busy && !rd_valid && !wr_ack && !bus_err, "R11 reset outputs",
            64'({wb_cyc, busy, rd_valid, wr_ack, bus_err}), 64'd0);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            if (VEC[v][67:66] == 2'b10) set_adr(VEC[v][67:34]);
            else access(VEC[v][67:34], VEC[v][33:2], int'(VEC[v][1:0]), 1'b0, 1'b0);
        end

        // R1 idle opcode ignored; address stays at 8
        @(negedge clk); cmd_valid = 1'b1; cmd_word = 34'h3_0000_0100;
        @(negedge clk); cmd_valid = 1'b0;
        chk(!wb_cyc && !busy, "R1 no cycle for opcode 11", 64'(wb_cyc), 64'd0);
        access(34'h0_0000_0000, 32'h0000_0008, 0, 1'b0, 1'b0);

        // R9 error: no advance afterwards
        access(34'h0_0000_0000, 32'h0000_000C, 1, 1'b1, 1'b0);
        access(34'h0_0000_0000, 32'h0000_000C, 0, 1'b0, 1'b0);

        // R10 command during busy dropped; next read at 0x14
        access(34'h0_0000_0000, 32'h0000_0010, 2, 1'b0, 1'b1);
        access(34'h0_0000_0000, 32'h0000_0014, 0, 1'b0, 1'b0);

        // R11 reset mid-cycle after selecting hold mode
        set_adr(34'h2_0000_0101);
        @(negedge clk); cmd_valid = 1'b1; cmd_word = 34'h0_0000_0000;
        @(negedge clk); cmd_valid = 1'b0;
        chk(wb_cyc && wb_adr == 30'h40, "R11 cycle open before reset", 64'(wb_adr), 64'h40);
        rst_n = 1'b0;
        @(negedge clk);
        chk(!wb_cyc && !busy && !rd_valid, "R11 reset aborts cycle", 64'({wb_cyc, busy, rd_valid}), 64'd0);
        rst_n = 1'b1;
        access(34'h0_0000_0000, 32'h0000_0000, 0, 1'b0, 1'b0);
        access(34'h0_0000_0000, 32'h0000_0004, 0, 1'b0, 1'b0);  // R11 advance enabled

        finished = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            checks++;
            errors++;
            $display("FAIL watchdog R10 actual=hung expected=done");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule